// File: doc/BRIEF.md
# I2C Master Multi-Message Sequencer

This block is the control layer above a byte-level I2C master shifter. A caller fills a small descriptor table (one entry per message: 7-bit target address, read/write direction, byte length, and a flag that joins the message to the previous one with no restart). The caller also fills a byte buffer, then pulses `go` with the number of messages. The sequencer waits until the bus and the shifter are idle. It then walks the message list and hands the shifter one command per byte. Each command says whether to transmit or receive, and whether to generate a start, a stop or a NAK on that byte. Write data comes from the buffer and read data goes back into it, both at one running offset that carries across messages.

The shifter answers each command with a "transmit empty" or "receive full" pulse. A bus-error flag and a NAK flag may accompany that pulse. A NAK on the very first address of the list, before any data has moved, causes the whole list to be restarted after a fresh wait for an idle bus. The same restart follows when the idle wait times out. The number of restarts is bounded. Any other NAK, or a bus error without NAK, ends the run with its own result code. When the final message has zero length it is an address probe, and successful completion also pulses a reset request to the controller.

Top module: `i2cseq_master`

## Requirements
- R1: The first command of each attempt carries start=1, recv=0 and the data byte {address[6:0], read}, where read is 1 for a read message.
- R2: Write bytes are sent from the buffer at the running offset, which advances by one per byte. The last byte of the last message is sent with stop=1, and every other write byte has stop=0.
- R3: Read bytes are requested with recv=1 and stored into the buffer at the running offset. The final byte of each read message is requested with nak=1, and with stop=1 too when that message is the last one.
- R4: When a message ends and another follows without the no-restart flag, the next command has start=1 and carries the next message's address byte.
- R5: A message with the no-restart flag set produces no address command. Its data continues directly, with start=0.
- R6: A NAK during the address of the first message restarts the attempt: a fresh idle wait, then the address command again. Each restart increments `res_tries`.
- R7: After MAX_RETRY restarts, the next retry condition ends the run with res_code=3 (fail) and res_msgs=0.
- R8: A NAK at any later point (a data byte, or the address of a later message) ends the run with res_code=1. res_msgs is the number of messages fully completed.
- R9: A bus error without NAK ends the run with res_code=2.
- R10: No command is issued while `bus_busy` or `unit_busy` is high. WAIT_CYC consecutive busy cycles in the wait count as a retry condition.
- R11: A successful run whose last message has length zero pulses `ctrl_reset` in the same cycle as `done`.
- R12: A successful run pulses `done` with res_code=0 and res_msgs equal to the message count. A count of zero completes at once with no command.
- R13: Out of reset, `done`, `sh_go`, `buf_we` and `ctrl_reset` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start a run of `msg_count` messages |
| msg_count | input | CNT_W | Number of messages, 0..MAX_MSG |
| desc_idx | output | IDX_W | Descriptor table index being read |
| desc_addr | input | 7 | Target address of indexed message |
| desc_read | input | 1 | 1 = read message |
| desc_len | input | LEN_W | Byte length of indexed message |
| desc_nostart | input | 1 | Join to previous message without restart |
| buf_ofs | output | OFS_W | Running byte offset into the data buffer |
| buf_rdata | input | 8 | Buffer byte at `buf_ofs` |
| buf_wdata | output | 8 | Received byte to store |
| buf_we | output | 1 | Store `buf_wdata` at `buf_ofs` |
| sh_go | output | 1 | One-cycle command strobe to the shifter |
| sh_start | output | 1 | Generate (repeated) start before this byte |
| sh_stop | output | 1 | Generate stop after this byte |
| sh_nak | output | 1 | NAK the received byte |
| sh_recv | output | 1 | 1 = receive a byte, 0 = transmit `sh_data` |
| sh_data | output | 8 | Byte to transmit |
| sh_tx_empty | input | 1 | Transmit byte done pulse |
| sh_rx_full | input | 1 | Receive byte done pulse |
| sh_rx_data | input | 8 | Received byte |
| sh_bus_err | input | 1 | Error flag alongside a done pulse |
| sh_nak_rcvd | input | 1 | NAK flag alongside a done pulse |
| bus_busy | input | 1 | Bus is occupied |
| unit_busy | input | 1 | Shifter is occupied |
| ctrl_reset | output | 1 | Controller reset request after a probe |
| done | output | 1 | Run finished, result valid |
| res_code | output | 2 | 0 ok, 1 NAKed, 2 bus error, 3 fail |
| res_msgs | output | CNT_W | Messages completed |
| res_tries | output | TRY_W | Restarts used |

## Verification
The bench builds the block with MAX_MSG=4, LEN_W=4, BUF_DEPTH=16 and MAX_RETRY=5. With those values it can run random lists of up to four messages with mixed directions, no-restart joins and zero-length probes, and the running offset still stays inside the buffer. WAIT_CYC is set to 12 rather than its large default. A bus held busy then exhausts all five restarts in under a hundred cycles. A busy period just under the limit shows that the wait does not time out early.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NAKED  = 2'd1,
        RES_BUSERR = 2'd2,
        RES_FAIL   = 2'd3
    } res_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ADDR,
        ST_XFER,
        ST_NEXT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        logic       go;
        logic       start;
        logic       stop;
        logic       nak;
        logic       recv;
        logic [7:0] data;
    } shcmd_t;

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rd);
        return {a, rd};
    endfunction

endpackage

// File: rtl/i2cseq_freewait.sv
module i2cseq_freewait #(
    parameter int WAIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic bus_busy,
    input  logic unit_busy,
    output logic free,
    output logic expired
);
    localparam int WAIT_W = $clog2(WAIT_CYC + 1);
    localparam logic [WAIT_W-1:0] LIMIT = WAIT_W'(WAIT_CYC - 1);

    logic [WAIT_W-1:0] cnt;
    logic              busy;

    assign busy    = bus_busy | unit_busy;
    assign free    = active & ~busy;
    assign expired = active & busy & (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !active || !busy || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + WAIT_W'(1);
        end
    end

    // R10: a timeout can only follow at least one earlier cycle of waiting
    a_r10_no_early_timeout: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(active));

endmodule

// File: rtl/i2cseq_retry.sv
module i2cseq_retry #(
    parameter int MAX_RETRY = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             bump,
    output logic [$clog2(MAX_RETRY+1)-1:0]   tries,
    output logic                             exhausted
);
    localparam int TRY_W = $clog2(MAX_RETRY + 1);

    assign exhausted = (tries == TRY_W'(MAX_RETRY));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries <= '0;
        end else if (bump) begin
            tries <= tries + TRY_W'(1);
        end
    end

    // R7: the controller never asks for a restart past the bound
    a_r7_no_bump_past_limit: assert property (@(posedge clk) disable iff (rst)
        bump |-> !exhausted);

    // R7: the restart count stays within its bound
    a_r7_tries_bounded: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_W'(MAX_RETRY));

endmodule

// File: rtl/i2cseq_cursor.sv
module i2cseq_cursor #(
    parameter int IDX_W = 2,
    parameter int LEN_W = 4,
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             nxt,
    output logic [IDX_W-1:0] idx,
    output logic [LEN_W-1:0] ptr,
    output logic [OFS_W-1:0] ofs
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
            ptr <= '0;
            ofs <= '0;
        end else begin
            if (adv) begin
                ofs <= ofs + OFS_W'(1);
            end
            if (nxt) begin
                idx <= idx + IDX_W'(1);
                ptr <= '0;
            end else if (adv) begin
                ptr <= ptr + LEN_W'(1);
            end
        end
    end

    // R6: a restart of the attempt never coincides with byte or message stepping
    a_r6_clear_exclusive: assert property (@(posedge clk) disable iff (rst)
        clr |-> (!adv && !nxt));

endmodule

// File: rtl/i2cseq_master.sv
module i2cseq_master
    import i2cseq_pkg::*;
#(
    parameter int MAX_MSG   = 4,
    parameter int LEN_W     = 4,
    parameter int BUF_DEPTH = 16,
    parameter int MAX_RETRY = 5,
    parameter int WAIT_CYC  = 1000,
    localparam int IDX_W    = $clog2(MAX_MSG),
    localparam int CNT_W    = $clog2(MAX_MSG + 1),
    localparam int OFS_W    = $clog2(BUF_DEPTH),
    localparam int TRY_W    = $clog2(MAX_RETRY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [CNT_W-1:0] msg_count,
    output logic [IDX_W-1:0] desc_idx,
    input  logic [6:0]       desc_addr,
    input  logic             desc_read,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_nostart,
    output logic [OFS_W-1:0] buf_ofs,
    input  logic [7:0]       buf_rdata,
    output logic [7:0]       buf_wdata,
    output logic             buf_we,
    output logic             sh_go,
    output logic             sh_start,
    output logic             sh_stop,
    output logic             sh_nak,
    output logic             sh_recv,
    output logic [7:0]       sh_data,
    input  logic             sh_tx_empty,
    input  logic             sh_rx_full,
    input  logic [7:0]       sh_rx_data,
    input  logic             sh_bus_err,
    input  logic             sh_nak_rcvd,
    input  logic             bus_busy,
    input  logic             unit_busy,
    output logic             ctrl_reset,
    output logic             done,
    output logic [1:0]       res_code,
    output logic [CNT_W-1:0] res_msgs,
    output logic [TRY_W-1:0] res_tries
);
    localparam logic [LEN_W:0] ONE_X = (LEN_W + 1)'(1);

    seq_state_e       st, st_n;
    phase_e           ph, ph_n;
    shcmd_t           cmd_q, cmd_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] ptr;
    logic [OFS_W-1:0] ofs;
    logic             c_clr, c_adv, c_nxt;
    logic             r_clr, r_bump, r_exh;
    logic [TRY_W-1:0] tries;
    logic             w_free, w_exp;

    logic             last_msg;
    logic [LEN_W:0]   len_x, ptr_x, rx_ix;
    logic             cont, rxreq, msg_done, do_retry, we;
    logic             fin, fin_probe;
    res_code_e        fin_code;
    logic [CNT_W-1:0] fin_msgs;

    i2cseq_cursor #(.IDX_W(IDX_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_cursor (
        .clk(clk), .rst(rst), .clr(c_clr), .adv(c_adv), .nxt(c_nxt),
        .idx(idx), .ptr(ptr), .ofs(ofs)
    );

    i2cseq_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
        .clk(clk), .rst(rst), .clr(r_clr), .bump(r_bump),
        .tries(tries), .exhausted(r_exh)
    );

    i2cseq_freewait #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk(clk), .rst(rst), .active(st == ST_WAIT),
        .bus_busy(bus_busy), .unit_busy(unit_busy),
        .free(w_free), .expired(w_exp)
    );

    assign len_x    = {1'b0, desc_len};
    assign ptr_x    = {1'b0, ptr};
    assign last_msg = (CNT_W'(idx) + CNT_W'(1)) == cnt_q;

    always_comb begin
        st_n      = st;
        ph_n      = ph;
        cnt_n     = cnt_q;
        cmd_n     = '0;
        c_clr     = 1'b0;
        c_adv     = 1'b0;
        c_nxt     = 1'b0;
        r_clr     = 1'b0;
        r_bump    = 1'b0;
        cont      = 1'b0;
        rxreq     = 1'b0;
        rx_ix     = ptr_x;
        msg_done  = 1'b0;
        do_retry  = 1'b0;
        we        = 1'b0;
        fin       = 1'b0;
        fin_probe = 1'b0;
        fin_code  = RES_OK;
        fin_msgs  = '0;

        case (st)
            ST_IDLE: begin
                if (go) begin
                    cnt_n = msg_count;
                    if (msg_count == '0) begin
                        fin = 1'b1;
                    end else begin
                        r_clr = 1'b1;
                        st_n  = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (w_free) begin
                    c_clr = 1'b1;
                    st_n  = ST_ADDR;
                end else if (w_exp) begin
                    do_retry = 1'b1;
                end
            end
            ST_ADDR: begin
                cmd_n.go    = 1'b1;
                cmd_n.start = 1'b1;
                cmd_n.data  = addr_byte(desc_addr, desc_read);
                ph_n        = PH_ADDR;
                st_n        = ST_XFER;
            end
            ST_XFER: begin
                if ((sh_tx_empty || sh_rx_full) && sh_bus_err) begin
                    if (sh_nak_rcvd) begin
                        if (ph == PH_ADDR && idx == '0) begin
                            do_retry = 1'b1;
                        end else begin
                            fin      = 1'b1;
                            fin_code = RES_NAKED;
                            fin_msgs = CNT_W'(idx);
                        end
                    end else begin
                        fin      = 1'b1;
                        fin_code = RES_BUSERR;
                        fin_msgs = CNT_W'(idx);
                    end
                end else if (sh_tx_empty) begin
                    if (ph == PH_ADDR && desc_read && desc_len != '0) begin
                        rxreq = 1'b1;
                    end else begin
                        cont = 1'b1;
                    end
                end else if (sh_rx_full && ph == PH_RD) begin
                    we    = 1'b1;
                    c_adv = 1'b1;
                    if (ptr_x + ONE_X < len_x) begin
                        rxreq = 1'b1;
                        rx_ix = ptr_x + ONE_X;
                    end else begin
                        msg_done = 1'b1;
                    end
                end
            end
            ST_NEXT: begin
                if (desc_nostart) begin
                    if (desc_read && desc_len != '0) begin
                        rxreq = 1'b1;
                    end else begin
                        cont = 1'b1;
                    end
                end else begin
                    cmd_n.go    = 1'b1;
                    cmd_n.start = 1'b1;
                    cmd_n.data  = addr_byte(desc_addr, desc_read);
                    ph_n        = PH_ADDR;
                    st_n        = ST_XFER;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        // continue transmitting the current message, or close it
        if (cont) begin
            if (ptr_x < len_x) begin
                cmd_n.go   = 1'b1;
                cmd_n.data = buf_rdata;
                cmd_n.stop = (ptr_x + ONE_X == len_x) && last_msg;
                c_adv      = 1'b1;
                ph_n       = PH_WR;
                st_n       = ST_XFER;
            end else begin
                msg_done = 1'b1;
            end
        end

        // request one received byte
        if (rxreq) begin
            cmd_n.go   = 1'b1;
            cmd_n.recv = 1'b1;
            cmd_n.nak  = (rx_ix + ONE_X == len_x);
            cmd_n.stop = cmd_n.nak && last_msg;
            ph_n       = PH_RD;
            st_n       = ST_XFER;
        end

        if (msg_done) begin
            if (last_msg) begin
                fin       = 1'b1;
                fin_code  = RES_OK;
                fin_msgs  = cnt_q;
                fin_probe = (desc_len == '0);
            end else begin
                c_nxt = 1'b1;
                st_n  = ST_NEXT;
            end
        end

        if (do_retry) begin
            if (r_exh) begin
                fin      = 1'b1;
                fin_code = RES_FAIL;
                fin_msgs = '0;
            end else begin
                r_bump = 1'b1;
                st_n   = ST_WAIT;
            end
        end

        if (fin) begin
            st_n = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= PH_ADDR;
            cnt_q      <= '0;
            cmd_q      <= '0;
            done       <= 1'b0;
            ctrl_reset <= 1'b0;
            res_code   <= RES_OK;
            res_msgs   <= '0;
            res_tries  <= '0;
        end else begin
            st         <= st_n;
            ph         <= ph_n;
            cnt_q      <= cnt_n;
            cmd_q      <= cmd_n;
            done       <= fin;
            ctrl_reset <= fin && fin_probe;
            if (fin) begin
                res_code  <= fin_code;
                res_msgs  <= fin_msgs;
                res_tries <= tries;
            end
        end
    end

    assign desc_idx  = idx;
    assign buf_ofs   = ofs;
    assign buf_wdata = sh_rx_data;
    assign buf_we    = we;
    assign sh_go     = cmd_q.go;
    assign sh_start  = cmd_q.start;
    assign sh_stop   = cmd_q.stop;
    assign sh_nak    = cmd_q.nak;
    assign sh_recv   = cmd_q.recv;
    assign sh_data   = cmd_q.data;

    // R1: an address command is always a transmit
    a_r1_start_is_transmit: assert property (@(posedge clk) disable iff (rst)
        (sh_go && sh_start) |-> !sh_recv);

    // R3: a stop on a received byte always goes with a NAK
    a_r3_stop_with_nak: assert property (@(posedge clk) disable iff (rst)
        (sh_go && sh_recv && sh_stop) |-> sh_nak);

    // R12: a result is never presented together with a shifter command
    a_r12_done_no_cmd: assert property (@(posedge clk) disable iff (rst)
        done |-> !sh_go);

    // R11: the probe reset only comes with a successful result
    a_r11_reset_on_ok: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |-> (done && res_code == RES_OK));

    // R10: no command is ever launched straight out of idle
    a_r10_cmd_after_wait: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && go) |=> !sh_go);

endmodule

// File: tb/tb_i2cseq_master.sv
module tb_i2cseq_master;

    localparam int MAX_MSG   = 4;
    localparam int LEN_W     = 4;
    localparam int BUF_DEPTH = 16;
    localparam int MAX_RETRY = 5;
    localparam int WAIT_CYC  = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic       go;
    logic [2:0] msg_count;
    logic [1:0] desc_idx;
    logic [6:0] desc_addr;
    logic       desc_read;
    logic [3:0] desc_len;
    logic       desc_nostart;
    logic [3:0] buf_ofs;
    logic [7:0] buf_rdata;
    logic [7:0] buf_wdata;
    logic       buf_we;
    logic       sh_go, sh_start, sh_stop, sh_nak, sh_recv;
    logic [7:0] sh_data;
    logic       sh_tx_empty, sh_rx_full, sh_bus_err, sh_nak_rcvd;
    logic [7:0] sh_rx_data;
    logic       bus_busy, unit_busy;
    logic       ctrl_reset, done;
    logic [1:0] res_code;
    logic [2:0] res_msgs;
    logic [2:0] res_tries;

    always #4 clk = ~clk;

    // descriptor table and data buffer
    logic [6:0] t_addr [0:3];
    logic       t_rd   [0:3];
    logic [3:0] t_len  [0:3];
    logic       t_ns   [0:3];
    logic [7:0] mem    [0:15];
    logic [7:0] emem   [0:15];

    assign desc_addr    = t_addr[desc_idx];
    assign desc_read    = t_rd[desc_idx];
    assign desc_len     = t_len[desc_idx];
    assign desc_nostart = t_ns[desc_idx];
    assign buf_rdata    = mem[buf_ofs];

    always @(posedge clk) begin
        if (buf_we) mem[buf_ofs] <= buf_wdata;
    end

    i2cseq_master #(
        .MAX_MSG(MAX_MSG), .LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH),
        .MAX_RETRY(MAX_RETRY), .WAIT_CYC(WAIT_CYC)
    ) dut (
        .clk(clk), .rst(rst), .go(go), .msg_count(msg_count),
        .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_read(desc_read),
        .desc_len(desc_len), .desc_nostart(desc_nostart),
        .buf_ofs(buf_ofs), .buf_rdata(buf_rdata), .buf_wdata(buf_wdata), .buf_we(buf_we),
        .sh_go(sh_go), .sh_start(sh_start), .sh_stop(sh_stop), .sh_nak(sh_nak),
        .sh_recv(sh_recv), .sh_data(sh_data),
        .sh_tx_empty(sh_tx_empty), .sh_rx_full(sh_rx_full), .sh_rx_data(sh_rx_data),
        .sh_bus_err(sh_bus_err), .sh_nak_rcvd(sh_nak_rcvd),
        .bus_busy(bus_busy), .unit_busy(unit_busy),
        .ctrl_reset(ctrl_reset), .done(done), .res_code(res_code),
        .res_msgs(res_msgs), .res_tries(res_tries)
    );

    int nchk = 0;
    int nfail = 0;

    // command log from the shifter model
    int         lg_n;
    logic       lg_start [0:63];
    logic       lg_stop  [0:63];
    logic       lg_nak   [0:63];
    logic       lg_recv  [0:63];
    logic [7:0] lg_data  [0:63];

    // expected command list
    int         ex_n;
    logic       ex_start [0:63];
    logic       ex_stop  [0:63];
    logic       ex_nak   [0:63];
    logic       ex_recv  [0:63];
    logic [7:0] ex_data  [0:63];

    // fault injection window on the global command index
    int inj_lo, inj_hi;
    bit inj_nak;

    // captured result
    int  r_code, r_msgs, r_tries;
    bit  r_reset;

    function automatic logic [7:0] rxval(input int k);
        return 8'(k * 29 + 7);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // shifter model: answers each command two cycles later
    initial begin : responder
        int  cd;
        int  pk;
        bit  prc;
        cd = 0; pk = 0; prc = 1'b0;
        sh_tx_empty = 1'b0; sh_rx_full = 1'b0; sh_bus_err = 1'b0;
        sh_nak_rcvd = 1'b0; sh_rx_data = 8'h00;
        forever begin
            @(negedge clk);
            sh_tx_empty = 1'b0; sh_rx_full = 1'b0;
            sh_bus_err = 1'b0; sh_nak_rcvd = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    if (prc) begin
                        sh_rx_data = rxval(pk);
                        sh_rx_full = 1'b1;
                    end else begin
                        sh_tx_empty = 1'b1;
                    end
                    if (pk >= inj_lo && pk < inj_hi) begin
                        sh_bus_err  = 1'b1;
                        sh_nak_rcvd = inj_nak;
                    end
                end
            end
            if (sh_go === 1'b1) begin
                if (lg_n < 64) begin
                    lg_start[lg_n] = sh_start;
                    lg_stop[lg_n]  = sh_stop;
                    lg_nak[lg_n]   = sh_nak;
                    lg_recv[lg_n]  = sh_recv;
                    lg_data[lg_n]  = sh_data;
                end
                pk  = lg_n;
                prc = sh_recv;
                lg_n++;
                cd  = 2;
            end
        end
    end

    task automatic add_exp(input logic s, input logic p, input logic n,
                           input logic r, input logic [7:0] d);
        ex_start[ex_n] = s; ex_stop[ex_n] = p; ex_nak[ex_n] = n;
        ex_recv[ex_n] = r; ex_data[ex_n] = d;
        ex_n++;
    endtask

    task automatic build_exp(input int n);
        int ofs;
        ex_n = 0;
        ofs = 0;
        for (int a = 0; a < 16; a++) emem[a] = mem[a];
        for (int i = 0; i < n; i++) begin
            bit last;
            last = (i == n - 1);
            if (i == 0 || !t_ns[i]) add_exp(1'b1, 1'b0, 1'b0, 1'b0, {t_addr[i], t_rd[i]});
            for (int b = 0; b < int'(t_len[i]); b++) begin
                bit fb;
                fb = (b == int'(t_len[i]) - 1);
                if (t_rd[i]) begin
                    emem[ofs] = rxval(ex_n);
                    add_exp(1'b0, fb && last, fb, 1'b1, 8'h00);
                end else begin
                    add_exp(1'b0, fb && last, 1'b0, 1'b0, mem[ofs]);
                end
                ofs++;
            end
        end
    endtask

    task automatic cmp_log(input string tag);
        int mism;
        mism = 0;
        check({tag, " command count"}, lg_n, ex_n);
        for (int k = 0; k < ex_n && k < lg_n && k < 64; k++) begin
            if (lg_start[k] !== ex_start[k] || lg_stop[k] !== ex_stop[k] ||
                lg_nak[k] !== ex_nak[k] || lg_recv[k] !== ex_recv[k] ||
                (!ex_recv[k] && lg_data[k] !== ex_data[k])) mism++;
        end
        check({tag, " command fields mismatches"}, mism, 0);
    endtask

    task automatic cmp_mem(input string tag);
        int mism;
        mism = 0;
        for (int a = 0; a < 16; a++) if (mem[a] !== emem[a]) mism++;
        check({tag, " buffer mismatches"}, mism, 0);
    endtask

    task automatic start_txn(input int n);
        lg_n = 0;
        msg_count = 3'(n);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        k = 0;
        while (done !== 1'b1 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (done !== 1'b1) begin
            nchk++;
            nfail++;
            $display("FAIL %s: actual no done expected done", tag);
        end
        r_code  = int'(res_code);
        r_msgs  = int'(res_msgs);
        r_tries = int'(res_tries);
        r_reset = ctrl_reset;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_msg(input int i, input logic [6:0] a, input logic rd,
                           input int len, input logic ns);
        t_addr[i] = a; t_rd[i] = rd; t_len[i] = 4'(len); t_ns[i] = ns;
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 16; a++) mem[a] = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R12: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; go = 1'b0; msg_count = '0;
        bus_busy = 1'b0; unit_busy = 1'b0;
        inj_lo = 0; inj_hi = 0; inj_nak = 1'b0;
        lg_n = 0;
        for (int i = 0; i < 4; i++) set_msg(i, 7'h00, 1'b0, 0, 1'b0);
        fill_mem();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check("R13 done after reset", int'(done), 0);
        check("R13 sh_go after reset", int'(sh_go), 0);
        check("R13 buf_we after reset", int'(buf_we), 0);
        check("R13 ctrl_reset after reset", int'(ctrl_reset), 0);

        // R12 zero message count
        start_txn(0);
        wait_done("R12 zero count");
        check("R12 zero count code", r_code, 0);
        check("R12 zero count msgs", r_msgs, 0);
        check("R12 zero count no commands", lg_n, 0);

        // R1 R2 single write of three bytes
        set_msg(0, 7'h52, 1'b0, 3, 1'b0);
        fill_mem(); build_exp(1);
        start_txn(1); wait_done("R2 write");
        cmp_log("R1 R2 write");
        check("R1 address byte", int'(lg_data[0]), 8'hA4);
        check("R2 write code", r_code, 0);

        // R3 single read of one byte: NAK and stop on it
        set_msg(0, 7'h31, 1'b1, 1, 1'b0);
        fill_mem(); build_exp(1);
        start_txn(1); wait_done("R3 read1");
        cmp_log("R3 read1");
        check("R3 read1 nak", int'(lg_nak[1]), 1);
        check("R3 read1 stop", int'(lg_stop[1]), 1);
        cmp_mem("R3 read1");

        // R4 write then read with repeated start
        set_msg(0, 7'h10, 1'b0, 2, 1'b0);
        set_msg(1, 7'h10, 1'b1, 2, 1'b0);
        fill_mem(); build_exp(2);
        start_txn(2); wait_done("R4 restart");
        cmp_log("R4 restart");
        check("R4 second start", int'(lg_start[3]), 1);
        check("R4 second address", int'(lg_data[3]), 8'h21);
        cmp_mem("R4 restart");
        check("R12 restart msgs", r_msgs, 2);

        // R5 no-restart continuation of writes
        set_msg(0, 7'h44, 1'b0, 1, 1'b0);
        set_msg(1, 7'h44, 1'b0, 2, 1'b1);
        fill_mem(); build_exp(2);
        start_txn(2); wait_done("R5 join");
        cmp_log("R5 join");
        check("R5 joined count", lg_n, 4);
        check("R5 no start on join", int'(lg_start[2]), 0);

        // R11 probe
        set_msg(0, 7'h50, 1'b0, 0, 1'b0);
        fill_mem(); build_exp(1);
        start_txn(1); wait_done("R11 probe");
        cmp_log("R11 probe");
        check("R11 probe reset pulse", int'(r_reset), 1);
        check("R11 probe code", r_code, 0);

        // R6 address NAK twice, then success
        set_msg(0, 7'h22, 1'b0, 1, 1'b0);
        fill_mem();
        inj_lo = 0; inj_hi = 2; inj_nak = 1'b1;
        start_txn(1); wait_done("R6 retry");
        check("R6 retry code", r_code, 0);
        check("R6 retry tries", r_tries, 2);
        check("R6 retry commands", lg_n, 4);
        check("R6 third address start", int'(lg_start[2]), 1);

        // R7 address NAK forever
        inj_lo = 0; inj_hi = 1000; inj_nak = 1'b1;
        start_txn(1); wait_done("R7 exhaust");
        check("R7 exhaust code", r_code, 3);
        check("R7 exhaust msgs", r_msgs, 0);
        check("R7 exhaust tries", r_tries, MAX_RETRY);
        check("R7 exhaust addresses", lg_n, MAX_RETRY + 1);

        // R8 NAK on a data byte
        set_msg(0, 7'h22, 1'b0, 2, 1'b0);
        inj_lo = 1; inj_hi = 2; inj_nak = 1'b1;
        start_txn(1); wait_done("R8 data nak");
        check("R8 data nak code", r_code, 1);
        check("R8 data nak msgs", r_msgs, 0);
        check("R8 data nak tries", r_tries, 0);

        // R8 NAK on the address of the second message
        set_msg(0, 7'h22, 1'b0, 1, 1'b0);
        set_msg(1, 7'h23, 1'b0, 1, 1'b0);
        inj_lo = 2; inj_hi = 3; inj_nak = 1'b1;
        start_txn(2); wait_done("R8 second address nak");
        check("R8 second address code", r_code, 1);
        check("R8 second address msgs", r_msgs, 1);

        // R9 bus error without NAK
        set_msg(0, 7'h22, 1'b0, 2, 1'b0);
        inj_lo = 1; inj_hi = 2; inj_nak = 1'b0;
        start_txn(1); wait_done("R9 bus error");
        check("R9 bus error code", r_code, 2);
        check("R9 bus error commands", lg_n, 2);
        inj_lo = 0; inj_hi = 0;

        // R10 busy forever: no command, retries run out
        bus_busy = 1'b1;
        start_txn(1); wait_done("R10 busy forever");
        check("R10 busy commands", lg_n, 0);
        check("R10 busy code", r_code, 3);
        check("R10 busy tries", r_tries, MAX_RETRY);
        bus_busy = 1'b0;

        // R10 unit busy just below the limit, then free
        unit_busy = 1'b1;
        start_txn(1);
        repeat (WAIT_CYC - 3) @(negedge clk);
        check("R10 no command while busy", lg_n, 0);
        unit_busy = 1'b0;
        wait_done("R10 short busy");
        check("R10 short busy code", r_code, 0);
        check("R10 short busy tries", r_tries, 0);

        // random message lists (R1 R2 R3 R4 R5 R11 R12)
        for (int it = 0; it < 40; it++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < 4; i++) begin
                logic rd, ns;
                rd = 1'($urandom % 2);
                ns = (i > 0) && ($urandom % 3 == 0);
                if (ns) rd = t_rd[i - 1];
                set_msg(i, 7'($urandom), rd, int'($urandom % 4), ns);
            end
            fill_mem(); build_exp(n);
            start_txn(n); wait_done("R12 random");
            cmp_log("R1 R2 R3 R4 R5 random");
            cmp_mem("R3 random");
            check("R12 random code", r_code, 0);
            check("R12 random msgs", r_msgs, n);
            check("R11 random probe", int'(r_reset), int'(t_len[n - 1] == 4'd0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule